// File: doc/BRIEF.md
# Tagged Multi-Page-Size Translation Cache

This block is a small, fully associative translation cache that sits beside a load/store or fetch pipeline. It keeps three independent entry arrays, one each for 4 KB, 2 MB and 1 GB pages. Every entry is tagged with a 12-bit address-space identifier, which gives 4096 distinct tags. A lookup searches all three arrays at the same time. The result (hit flag, physical address and page size code) is registered and appears one cycle after the request.

A page walker installs finished translations through a fill port. A fill is tagged with the identifier that is current at that moment. A control port carries four operations:

- switch identifier and discard every entry;
- switch identifier and keep every entry;
- drop the translation that covers one virtual page;
- drop every entry that belongs to one identifier.

Page walking, permission checks and coordination between cores are handled elsewhere.

Top module: `tagged_tlb`

## Requirements
- R1: The lookup result registers `lk_hit`, `lk_pa` and `lk_size` update one cycle after a cycle with `lk_valid` high. After an idle cycle or a miss, all three read zero.
- R2: The physical address is the stored frame bits above the page offset joined with the request's offset bits. The offset is bits 11:0 for 4 KB, 20:0 for 2 MB and 29:0 for 1 GB. Frame bits below that offset that are given at fill time are ignored.
- R3: A lookup hits only on an entry whose identifier equals the current identifier. A fill stores the current identifier. After reset the identifier is 0.
- R4: Control op 1 (switch, keep) loads `ctl_asid` as the current identifier and leaves every entry in place.
- R5: Control op 0 (switch, flush) loads `ctl_asid` as the current identifier and invalidates every entry in all three arrays.
- R6: Control op 2 (page drop) invalidates, in every array, the entries under the current identifier whose page covers `ctl_vpn`. All other entries stay.
- R7: Control op 3 (identifier drop) invalidates every entry tagged `ctl_asid`. When `ctl_asid` equals the current identifier, the operation has no effect.
- R8: When several arrays hit, the larger page wins. `lk_size` is 0 for 4 KB, 1 for 2 MB and 2 for 1 GB.
- R9: A fill takes the lowest-numbered invalid slot of its array. When the array is full, it takes the slot under a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, on each fill that had to evict.
- R10: A fill whose page already has an entry under the current identifier in the same array rewrites that entry. It takes no other slot and does not move the pointer.
- R11: A fill or control operation in the same cycle as a lookup is seen only by lookups issued in later cycles.
- R12: Reset leaves all arrays empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Registered hit flag |
| lk_pa | output | PA_W | Registered physical address (zero on miss) |
| lk_size | output | 2 | Registered page size code (zero on miss) |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VA_W-12 | Virtual address bits above 11 of the new page |
| fill_pfn | input | PA_W-12 | Physical address bits above 11 of the new frame |
| fill_size | input | 2 | Page size code of the new entry (0, 1 or 2) |
| ctl_valid | input | 1 | Control operation request |
| ctl_op | input | 2 | 0 switch+flush, 1 switch+keep, 2 page drop, 3 identifier drop |
| ctl_asid | input | ID_W | Identifier for switch or identifier drop |
| ctl_vpn | input | VA_W-12 | Virtual address bits above 11 for page drop |

## Verification
Every lookup result is due exactly one rising edge after the request. The bench drives each request on a falling edge and samples the outputs at the next falling edge, after that single register stage.

Fills and control operations change the arrays at the edge that ends their cycle. A lookup issued in the following cycle therefore sees the new state, and its result is checked one cycle later again. The bench also issues lookups in the same cycle as a fill or drop. There it expects the old state first and the new state on the next lookup.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  typedef enum logic [1:0] {
    SZ_4K = 2'd0,
    SZ_2M = 2'd1,
    SZ_1G = 2'd2
  } pg_size_e;

  typedef enum logic [1:0] {
    OP_SWITCH_FLUSH = 2'd0,
    OP_SWITCH_KEEP  = 2'd1,
    OP_DROP_PAGE    = 2'd2,
    OP_DROP_ID      = 2'd3
  } ctl_op_e;

  localparam int NUM_SIZES = 3;
  localparam int BASE_OFS  = 12;

  // offset width of the page size held by array s
  function automatic int size_ofs(input int s);
    case (s)
      0:       return 12;
      1:       return 21;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/tlbx_victim.sv
module tlbx_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic [ENTRIES-1:0] slot_match,
  output logic [IDX_W-1:0]   slot
);

  logic [IDX_W-1:0] rr;
  logic [IDX_W-1:0] match_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_match;
  logic             any_free;
  logic             evict;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    any_match = |slot_match;
    any_free  = ~&slot_valid;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (slot_match[i]) match_idx = IDX_W'(i);
      if (!slot_valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign evict = fill_en && !any_match && !any_free;
  assign slot  = any_match ? match_idx : (any_free ? free_idx : rr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr <= '0;
    end else if (evict) begin
      rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
    end
  end

  // R9: pointer never leaves the array
  p_rr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rr) < ENTRIES);

  // R10: a refill lands on the entry that already holds the page
  p_reuse_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && any_match) |-> slot_match[slot]);

  // R9: a fill into a non-full array does not evict a live entry
  p_free_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !any_match && any_free) |-> !slot_valid[slot]);

endmodule

// File: rtl/tlbx_bank.sv
module tlbx_bank #(
  parameter int ENTRIES = 8,
  parameter int OFS     = 12,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int ID_W    = 12,
  localparam int TAG_W = VA_W - OFS,
  localparam int FRM_W = PA_W - OFS,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [ID_W-1:0]  cur_id,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [FRM_W-1:0] fill_frame,
  input  logic             flush_all,
  input  logic             drop_pg_en,
  input  logic [TAG_W-1:0] drop_pg_tag,
  input  logic             drop_id_en,
  input  logic [ID_W-1:0]  drop_id,
  output logic             hit,
  output logic [PA_W-1:0]  hit_pa
);

  logic [ENTRIES-1:0] valid;
  logic [ENTRIES-1:0] valid_d;
  logic [TAG_W-1:0]   ent_tag   [ENTRIES];
  logic [ID_W-1:0]    ent_id    [ENTRIES];
  logic [FRM_W-1:0]   ent_frame [ENTRIES];

  // named match vectors, used by the logic and by the assertions
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fill_match;
  logic [ENTRIES-1:0] pg_match;
  logic [ENTRIES-1:0] id_match;
  logic [IDX_W-1:0]   slot;

  function automatic logic [TAG_W-1:0] tag_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFS];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [FRM_W-1:0] frm,
                                               input logic [VA_W-1:0]  va);
    return {frm, va[OFS-1:0]};
  endfunction

  function automatic logic id_present(input logic [ID_W-1:0] q);
    logic f;
    f = 1'b0;
    for (int i = 0; i < ENTRIES; i++) f |= valid[i] && (ent_id[i] == q);
    return f;
  endfunction

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i]   = valid[i] && (ent_id[i] == cur_id) && (ent_tag[i] == tag_of(lk_va));
      fill_match[i] = valid[i] && (ent_id[i] == cur_id) && (ent_tag[i] == fill_tag);
      pg_match[i]   = valid[i] && (ent_id[i] == cur_id) && (ent_tag[i] == drop_pg_tag);
      id_match[i]   = valid[i] && (ent_id[i] == drop_id);
    end
  end

  always_comb begin
    hit    = |lk_match;
    hit_pa = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) hit_pa |= join_pa(ent_frame[i], lk_va);
  end

  tlbx_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .slot_valid (valid),
    .slot_match (fill_match),
    .slot       (slot)
  );

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      valid_d[i] = valid[i];
      if (flush_all) valid_d[i] = 1'b0;
      if (drop_pg_en && pg_match[i]) valid_d[i] = 1'b0;
      if (drop_id_en && id_match[i]) valid_d[i] = 1'b0;
      if (fill_en && (slot == IDX_W'(i))) valid_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_tag[i]   <= '0;
        ent_id[i]    <= '0;
        ent_frame[i] <= '0;
      end
    end else begin
      valid <= valid_d;
      if (fill_en) begin
        ent_tag[slot]   <= fill_tag;
        ent_id[slot]    <= cur_id;
        ent_frame[slot] <= fill_frame;
      end
    end
  end

  // R10: a page has at most one live entry per identifier
  p_single_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R5: a flush with no fill leaves the array empty
  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_en) |=> (valid == '0));

  // R7: an identifier drop removes every entry of that identifier
  p_id_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_id_en && !fill_en) |=> !id_present($past(drop_id)));

  // R6: a page drop removes the named page under the current identifier
  p_page_gone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_pg_en && !fill_en) |=> ((valid & $past(pg_match)) == '0));

endmodule

// File: rtl/tlbx_pick.sv
module tlbx_pick #(
  parameter int PA_W = 40,
  parameter int NS   = 3
) (
  input  logic [NS-1:0]   hit_v,
  input  logic [PA_W-1:0] pa_v [NS],
  output logic            any,
  output logic [PA_W-1:0] pa,
  output logic [1:0]      size
);

  // larger page sizes sit at higher indices and override smaller ones
  always_comb begin
    any  = 1'b0;
    pa   = '0;
    size = 2'd0;
    for (int s = 0; s < NS; s++) begin
      if (hit_v[s]) begin
        any  = 1'b1;
        pa   = pa_v[s];
        size = 2'(s);
      end
    end
  end

endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tlbx_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 40,
  parameter int ID_W = 12,
  parameter int N4K  = 8,
  parameter int N2M  = 4,
  parameter int N1G  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_va,
  output logic               lk_hit,
  output logic [PA_W-1:0]    lk_pa,
  output logic [1:0]         lk_size,
  input  logic               fill_valid,
  input  logic [VA_W-13:0]   fill_vpn,
  input  logic [PA_W-13:0]   fill_pfn,
  input  logic [1:0]         fill_size,
  input  logic               ctl_valid,
  input  logic [1:0]         ctl_op,
  input  logic [ID_W-1:0]    ctl_asid,
  input  logic [VA_W-13:0]   ctl_vpn
);

  logic [ID_W-1:0]      cur_id;
  logic                 ev_flush;
  logic                 ev_switch;
  logic                 ev_drop_pg;
  logic                 ev_drop_id;
  logic [NUM_SIZES-1:0] bank_hit;
  logic [PA_W-1:0]      bank_pa [NUM_SIZES];
  logic                 sel_any;
  logic [PA_W-1:0]      sel_pa;
  logic [1:0]           sel_size;

  // decoded control events
  assign ev_flush   = ctl_valid && (ctl_op == OP_SWITCH_FLUSH);
  assign ev_switch  = ctl_valid && ((ctl_op == OP_SWITCH_FLUSH) || (ctl_op == OP_SWITCH_KEEP));
  assign ev_drop_pg = ctl_valid && (ctl_op == OP_DROP_PAGE);
  assign ev_drop_id = ctl_valid && (ctl_op == OP_DROP_ID) && (ctl_asid != cur_id);

  always_ff @(posedge clk) begin
    if (!rst_n) cur_id <= '0;
    else if (ev_switch) cur_id <= ctl_asid;
  end

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
    localparam int OFS = size_ofs(s);
    localparam int ENT = (s == 0) ? N4K : ((s == 1) ? N2M : N1G);
    localparam int SH  = OFS - BASE_OFS;

    tlbx_bank #(
      .ENTRIES (ENT),
      .OFS     (OFS),
      .VA_W    (VA_W),
      .PA_W    (PA_W),
      .ID_W    (ID_W)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .lk_va       (lk_va),
      .cur_id      (cur_id),
      .fill_en     (fill_valid && (fill_size == 2'(s))),
      .fill_tag    (fill_vpn[VA_W-13:SH]),
      .fill_frame  (fill_pfn[PA_W-13:SH]),
      .flush_all   (ev_flush),
      .drop_pg_en  (ev_drop_pg),
      .drop_pg_tag (ctl_vpn[VA_W-13:SH]),
      .drop_id_en  (ev_drop_id),
      .drop_id     (ctl_asid),
      .hit         (bank_hit[s]),
      .hit_pa      (bank_pa[s])
    );
  end

  tlbx_pick #(.PA_W(PA_W), .NS(NUM_SIZES)) u_pick (
    .hit_v (bank_hit),
    .pa_v  (bank_pa),
    .any   (sel_any),
    .pa    (sel_pa),
    .size  (sel_size)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit  <= 1'b0;
      lk_pa   <= '0;
      lk_size <= 2'd0;
    end else begin
      lk_hit  <= lk_valid && sel_any;
      lk_pa   <= (lk_valid && sel_any) ? sel_pa : '0;
      lk_size <= (lk_valid && sel_any) ? sel_size : 2'd0;
    end
  end

  // R1: no request, no hit in the next cycle
  p_idle_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_hit);

  // R1: a miss presents zero address and size
  p_miss_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0) && (lk_size == 2'd0));

  // R8: size code stays within the three page sizes
  p_size_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_size != 2'd3);

  // R4: a switch loads the requested identifier
  p_switch_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_switch |=> (cur_id == $past(ctl_asid)));

endmodule

// File: tb/sim_tagged_tlb.sv
`timescale 1ns/1ps
module sim_tagged_tlb;

  localparam int VA_W = 48;
  localparam int PA_W = 40;
  localparam int ID_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lk_valid = 1'b0;
  logic [VA_W-1:0]   lk_va = '0;
  logic              lk_hit;
  logic [PA_W-1:0]   lk_pa;
  logic [1:0]        lk_size;
  logic              fill_valid = 1'b0;
  logic [VA_W-13:0]  fill_vpn = '0;
  logic [PA_W-13:0]  fill_pfn = '0;
  logic [1:0]        fill_size = '0;
  logic              ctl_valid = 1'b0;
  logic [1:0]        ctl_op = '0;
  logic [ID_W-1:0]   ctl_asid = '0;
  logic [VA_W-13:0]  ctl_vpn = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tagged_tlb u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_size(lk_size),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_size(fill_size),
    .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_asid(ctl_asid), .ctl_vpn(ctl_vpn)
  );

  localparam logic [47:0] VA_B = 48'h00C0_4000_0000;

  function automatic logic [47:0] pg(input int i, input int off);
    return VA_B + (48'(i) << 12) + 48'(off);
  endfunction

  function automatic logic [39:0] pa4(input int i);
    return 40'h12_3450_0000 + (40'(i) << 12);
  endfunction

  // expected address: keep frame bits above the page offset, take the rest from va
  function automatic logic [39:0] xpa(input logic [39:0] base, input logic [47:0] va, input int sz);
    logic [39:0] mask;
    mask = (40'd1 << ((sz == 0) ? 12 : ((sz == 1) ? 21 : 30))) - 40'd1;
    return (base & ~mask) | (va[39:0] & mask);
  endfunction

  task automatic judge(input string req, input bit eh, input logic [1:0] es, input logic [39:0] ep);
    total++;
    if (lk_hit !== eh || lk_size !== es || lk_pa !== ep) begin
      bad++;
      $display("FAIL %s: got hit=%0b size=%0d pa=%h, want hit=%0b size=%0d pa=%h",
               req, lk_hit, lk_size, lk_pa, eh, es, ep);
    end
  endtask

  task automatic look(input logic [47:0] va, input string req,
                      input bit eh, input logic [1:0] es, input logic [39:0] ep);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va;
    @(negedge clk);
    lk_valid = 1'b0;
    judge(req, eh, es, ep);
  endtask

  task automatic fill(input logic [47:0] va, input logic [39:0] pa, input logic [1:0] sz);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = va[47:12]; fill_pfn = pa[39:12]; fill_size = sz;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic ctl(input logic [1:0] op, input logic [11:0] id, input logic [47:0] va);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_op = op; ctl_asid = id; ctl_vpn = va[47:12];
    @(negedge clk);
    ctl_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 / R1: empty after reset, miss reads zero
    look(pg(0, 0), "R12", 1'b0, 2'd0, '0);
    total++;
    if (lk_hit !== 1'b0 || lk_pa !== '0) begin
      bad++;
      $display("FAIL R1: idle got hit=%0b pa=%h, want 0 0", lk_hit, lk_pa);
    end

    // R2 / R9: fill all 4 KB slots, sweep offsets
    for (int i = 0; i < 8; i++) fill(pg(i, 0), pa4(i) | 40'hABC, 2'd0);
    for (int i = 0; i < 8; i++) look(pg(i, i * 517 + 3), "R2", 1'b1, 2'd0, xpa(pa4(i), pg(i, i * 517 + 3), 0));

    // R9: full array evicts round robin from slot 0
    fill(pg(8, 0), pa4(8), 2'd0);
    look(pg(0, 1), "R9", 1'b0, 2'd0, '0);
    look(pg(8, 2), "R9", 1'b1, 2'd0, xpa(pa4(8), pg(8, 2), 0));
    look(pg(1, 3), "R9", 1'b1, 2'd0, xpa(pa4(1), pg(1, 3), 0));
    fill(pg(9, 0), pa4(9), 2'd0);
    look(pg(1, 3), "R9", 1'b0, 2'd0, '0);
    look(pg(9, 4), "R9", 1'b1, 2'd0, xpa(pa4(9), pg(9, 4), 0));

    // R10: refill rewrites in place, nothing else evicted
    fill(pg(3, 0), 40'h0F_0000_7000, 2'd0);
    look(pg(3, 12'h155), "R10", 1'b1, 2'd0, xpa(40'h0F_0000_7000, pg(3, 12'h155), 0));
    for (int i = 4; i < 10; i++) look(pg(i, 8), "R10", 1'b1, 2'd0, xpa(pa4(i), pg(i, 8), 0));

    // R3 / R4: switch keep to identifier 5
    ctl(2'd1, 12'd5, '0);
    look(pg(4, 0), "R3", 1'b0, 2'd0, '0);
    fill(pg(4, 0), 40'h33_0000_1000, 2'd0);          // evicts slot 2 (page 2)
    look(pg(4, 9), "R3", 1'b1, 2'd0, xpa(40'h33_0000_1000, pg(4, 9), 0));
    ctl(2'd1, 12'd0, '0);
    look(pg(4, 9), "R4", 1'b1, 2'd0, xpa(pa4(4), pg(4, 9), 0));
    look(pg(2, 0), "R9", 1'b0, 2'd0, '0);

    // R7: drop of the current identifier has no effect; other identifier gone
    ctl(2'd3, 12'd0, '0);
    look(pg(4, 7), "R7", 1'b1, 2'd0, xpa(pa4(4), pg(4, 7), 0));
    ctl(2'd3, 12'd5, '0);
    ctl(2'd1, 12'd5, '0);
    look(pg(4, 7), "R7", 1'b0, 2'd0, '0);
    ctl(2'd1, 12'd0, '0);
    look(pg(4, 7), "R7", 1'b1, 2'd0, xpa(pa4(4), pg(4, 7), 0));

    // R6: single page drop
    ctl(2'd2, 12'd0, pg(5, 12'h321));
    look(pg(5, 0), "R6", 1'b0, 2'd0, '0);
    look(pg(6, 0), "R6", 1'b1, 2'd0, xpa(pa4(6), pg(6, 0), 0));

    // R11: drop and lookup in one cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_va = pg(6, 5);
    ctl_valid = 1'b1; ctl_op = 2'd2; ctl_asid = '0; ctl_vpn = pg(6, 0) >> 12;
    @(negedge clk);
    lk_valid = 1'b0; ctl_valid = 1'b0;
    judge("R11", 1'b1, 2'd0, xpa(pa4(6), pg(6, 5), 0));
    look(pg(6, 5), "R11", 1'b0, 2'd0, '0);

    // R8: larger page wins
    fill(VA_B, 40'h55_6660_0000, 2'd1);
    look(pg(7, 12'h777), "R8", 1'b1, 2'd1, xpa(40'h55_6660_0000, pg(7, 12'h777), 1));
    fill(VA_B, 40'h80_4000_0000, 2'd2);
    look(pg(7, 12'h777), "R8", 1'b1, 2'd2, xpa(40'h80_4000_0000, pg(7, 12'h777), 2));
    look(VA_B + 48'h2AB4_5678, "R2", 1'b1, 2'd2, xpa(40'h80_4000_0000, VA_B + 48'h2AB4_5678, 2));

    // R6: page drop reaches the large arrays too
    ctl(2'd2, 12'd0, pg(5, 0));
    look(pg(7, 12'h777), "R6", 1'b1, 2'd0, xpa(pa4(7), pg(7, 12'h777), 0));

    // R5: switch with flush clears everything
    ctl(2'd0, 12'd0, '0);
    look(pg(7, 0), "R5", 1'b0, 2'd0, '0);
    look(pg(8, 0), "R5", 1'b0, 2'd0, '0);

    // R11: fill and lookup in one cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_va = pg(10, 1);
    fill_valid = 1'b1; fill_vpn = pg(10, 0) >> 12; fill_pfn = pa4(10) >> 12; fill_size = 2'd0;
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    judge("R11", 1'b0, 2'd0, '0);
    look(pg(10, 1), "R11", 1'b1, 2'd0, xpa(pa4(10), pg(10, 1), 0));

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule